// File: doc/BRIEF.md
# Biphase-Mark Stereo Line Transmitter

This block turns a stream of 16-bit stereo PCM pairs into a single serial line that carries consumer digital audio framing. The line is driven at twice the bit rate, so every data bit spends two half-bit slots on the wire. A free-running slot divider sets the slot rate from the system clock. Each stereo frame holds a left subframe and then a right subframe, both 32 bits long. Each subframe opens with a fixed 16-slot sync group, followed by three groups that carry the audio payload, the sign-extension bit, zeroed flag bits and an even-parity bit.

Sample pairs come in through a valid/ready handshake. Ready pulses for one clock, on the slot tick where the next left subframe is about to start. A pair that is not valid in that cycle is replaced by silence, and the framing keeps running. A swap input selects whether the first byte of each sample word is the low byte or the high byte. A start pulse restarts the stream: the subframe count returns to zero and the line polarity returns to low.

The controller is a five-state machine. ARM waits for a slot tick after reset or start. SYNC shifts the sync group. LOW, MID and HIGH shift the three payload groups. The named transitions are:
- ARM→SYNC, which takes the first pair.
- SYNC→LOW, LOW→MID and MID→HIGH, each at the end of a group.
- HIGH→SYNC, at the end of a subframe. When the next subframe is a left one, this transition also takes a new pair.
- Any state→ARM, on start.

Top module: `bmc_line_tx`

## Requirements
- R1: The line changes only on a slot tick. A tick comes once every SLOT_DIV clocks, counted from the release of reset.
- R2: Each accepted or silent pair gives one frame of 128 slots: the left subframe and then the right subframe.
- R3: A subframe counter runs from 0 to 383 and wraps. Count 0 sends sync slots 0xE8CC, odd counts send 0xE4CC and other even counts send 0xE2CC, each transmitted MSB first.
- R4: The sample sits in subframe bits 11–26. Bit 27 repeats bit 26. Bits 8–10 and bits 28–30 are zero.
- R5: Bit 31 is set whenever needed to make bits 4–31 hold an even number of ones.
- R6: Payload bits 8–31 go out least significant bit first, two slots per bit. A zero gives two equal slots and a one gives two different slots. Each 8-bit group, taken alone, begins with a high slot.
- R7: When the slot just before a 16-slot group was high, the whole group, including a sync group, is sent inverted.
- R8: With swap low, bits [7:0] of a sample input are the sample's low byte. With swap high, bits [7:0] are its high byte.
- R9: pcm_ready is high for exactly the tick cycle that starts a left subframe. A pair is accepted when pcm_valid is high in that cycle.
- R10: When no pair is accepted, both subframes of that frame carry zero audio and zero parity. The sync groups and the subframe counting continue.
- R11: During reset the line and pcm_ready are low. A start pulse forces the line low and takes priority over a tick in the same cycle. The next tick after reset or start begins a count-0 subframe with polarity low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Restart pulse: subframe count 0, polarity low |
| swap | input | 1 | 1 = bits [7:0] of a sample word hold its high byte |
| pcm_valid | input | 1 | A sample pair is offered |
| pcm_left | input | 16 | Left sample word |
| pcm_right | input | 16 | Right sample word |
| pcm_ready | output | 1 | Pair taken in this cycle when pcm_valid is high |
| line_out | output | 1 | Registered biphase-mark line |

## Verification
Three events can fall in the same clock. A start pulse can coincide with a slot tick that would also end a frame and raise pcm_ready. Separately, the handshake can coincide with the subframe counter wrapping from 383 back to the block-start sync. The bench times start from its own slot counter so that the pulse lands exactly on a tick, and also places it off a tick. It then expects ready to stay low and the line to drop. A long run carries the stream across a full block, so the accepting tick lands on the wrap. Every slot is compared against a behavioural model that rebuilds each frame from the requirements.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

    // sync groups, 16 slots each, first slot in the MSB
    localparam logic [15:0] SYNC_BLOCK = 16'hE8CC;
    localparam logic [15:0] SYNC_RIGHT = 16'hE4CC;
    localparam logic [15:0] SYNC_LEFT  = 16'hE2CC;

    localparam int GROUP_SLOTS = 16;

    // payload carries subframe bits 8..31
    typedef logic [23:0] payload_t;

    typedef enum logic [2:0] {
        ST_ARM,
        ST_SYNC,
        ST_LOW,
        ST_MID,
        ST_HIGH
    } tx_state_e;

endpackage

// File: rtl/bmc_slot_timer.sv
module bmc_slot_timer #(
    parameter int DIV = 22
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (DIV <= 1) begin : g_every
            assign tick = rst_n;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt;

            assign tick = (cnt == CW'(DIV - 1));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (tick) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            // R1
            slot_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/bmc_subframe_pack.sv
module bmc_subframe_pack
    import bmc_pkg::*;
#(
    parameter int PCM_W   = 16,
    parameter int LSB_POS = 11
) (
    input  logic [PCM_W-1:0] pcm,
    input  logic             swap,
    input  logic             present,
    output payload_t         payload
);

    localparam int NBYTES = PCM_W / 8;
    localparam int BASE   = LSB_POS - 8;

    logic [PCM_W-1:0] reordered;
    logic [PCM_W-1:0] smp;
    payload_t         word;

    // reverse byte order for big-endian sample words
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign reordered[8*b +: 8] = pcm[8*(NBYTES-1-b) +: 8];
    end

    assign smp = swap ? reordered : pcm;

    always_comb begin
        word = '0;
        if (present) begin
            word[BASE +: PCM_W]   = smp;
            word[BASE + PCM_W]    = smp[PCM_W-1];
            word[23]              = ^word[22:0];
        end
    end

    assign payload = word;

    // R5
    always_comb begin
        if (!$isunknown(payload)) begin
            parity_even_chk: assert (^payload == 1'b0);
        end
    end

endmodule

// File: rtl/bmc_group_coder.sv
module bmc_group_coder (
    input  logic [7:0]  data,
    input  logic        flip,
    output logic [15:0] slots
);

    // level carried from the end of bit i-1 into bit i
    logic [7:0]  run;
    logic [15:0] raw;

    assign run[0] = 1'b0;

    for (genvar i = 0; i < 8; i++) begin : g_bit
        assign raw[15-2*i] = ~run[i];
        assign raw[14-2*i] = ~run[i] ^ data[i];
        if (i < 7) begin : g_carry
            assign run[i+1] = raw[14-2*i];
        end
    end

    assign slots = raw ^ {16{flip}};

endmodule

// File: rtl/bmc_line_tx.sv
module bmc_line_tx
    import bmc_pkg::*;
#(
    parameter int SLOT_DIV         = 22,
    parameter int PCM_W            = 16,
    parameter int FRAMES_PER_BLOCK = 192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             swap,
    input  logic             pcm_valid,
    input  logic [PCM_W-1:0] pcm_left,
    input  logic [PCM_W-1:0] pcm_right,
    output logic             pcm_ready,
    output logic             line_out
);

    localparam int SUBS  = 2 * FRAMES_PER_BLOCK;
    localparam int CNT_W = $clog2(SUBS);
    localparam logic [CNT_W-1:0] LAST_SUB = CNT_W'(SUBS - 1);
    localparam logic [3:0] LAST_SLOT = 4'(GROUP_SLOTS - 1);

    tx_state_e        state, nxt_state;
    logic             tick;
    logic [3:0]       slot_idx;
    logic [15:0]      shreg;
    logic [CNT_W-1:0] sf_cnt, nxt_cnt, new_cnt;
    payload_t         cur_pl, hold_r;
    payload_t         pl_ch [2];
    logic [PCM_W-1:0] pcm_ch [2];

    logic        load, enter_sub, new_left, take, last_hi;
    logic [15:0] sync_pat, coded_pat, nxt_pat;
    logic [7:0]  coder_byte;

    bmc_slot_timer #(.DIV(SLOT_DIV)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    assign pcm_ch[0] = pcm_left;
    assign pcm_ch[1] = pcm_right;

    for (genvar c = 0; c < 2; c++) begin : g_chan
        bmc_subframe_pack #(.PCM_W(PCM_W)) u_pack (
            .pcm    (pcm_ch[c]),
            .swap   (swap),
            .present(1'b1),
            .payload(pl_ch[c])
        );
    end

    // ---------------- control decode ----------------
    assign load      = tick && !start && (state == ST_ARM || slot_idx == LAST_SLOT);
    assign enter_sub = load && (state == ST_ARM || state == ST_HIGH);
    assign nxt_cnt   = (sf_cnt == LAST_SUB) ? '0 : sf_cnt + 1'b1;
    assign new_cnt   = (state == ST_ARM) ? '0 : nxt_cnt;
    assign new_left  = !new_cnt[0];
    assign pcm_ready = enter_sub && new_left;
    assign take      = pcm_ready && pcm_valid;
    assign last_hi   = (state == ST_ARM) ? 1'b0 : line_out;

    always_comb begin
        if (new_cnt == '0)
            sync_pat = SYNC_BLOCK;
        else if (new_cnt[0])
            sync_pat = SYNC_RIGHT;
        else
            sync_pat = SYNC_LEFT;
    end

    always_comb begin
        unique case (state)
            ST_SYNC: coder_byte = cur_pl[7:0];
            ST_LOW:  coder_byte = cur_pl[15:8];
            ST_MID:  coder_byte = cur_pl[23:16];
            default: coder_byte = 8'h00;
        endcase
    end

    bmc_group_coder u_coder (
        .data (coder_byte),
        .flip (last_hi),
        .slots(coded_pat)
    );

    assign nxt_pat = (state == ST_ARM || state == ST_HIGH)
                   ? (sync_pat ^ {16{last_hi}}) : coded_pat;

    // ---------------- next state ----------------
    always_comb begin
        nxt_state = state;
        if (start) begin
            nxt_state = ST_ARM;
        end else if (load) begin
            unique case (state)
                ST_ARM:  nxt_state = ST_SYNC;
                ST_SYNC: nxt_state = ST_LOW;
                ST_LOW:  nxt_state = ST_MID;
                ST_MID:  nxt_state = ST_HIGH;
                ST_HIGH: nxt_state = ST_SYNC;
                default: nxt_state = ST_ARM;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_ARM;
        else
            state <= nxt_state;
    end

    // ---------------- outputs and datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_out <= 1'b0;
            shreg    <= '0;
            slot_idx <= '0;
            sf_cnt   <= '0;
            cur_pl   <= '0;
            hold_r   <= '0;
        end else if (start) begin
            line_out <= 1'b0;
            shreg    <= '0;
            slot_idx <= '0;
            sf_cnt   <= '0;
        end else if (load) begin
            line_out <= nxt_pat[15];
            shreg    <= {nxt_pat[14:0], 1'b0};
            slot_idx <= '0;
            if (enter_sub) begin
                sf_cnt <= new_cnt;
                if (new_left) begin
                    cur_pl <= take ? pl_ch[0] : '0;
                    hold_r <= take ? pl_ch[1] : '0;
                end else begin
                    cur_pl <= hold_r;
                end
            end
        end else if (tick) begin
            line_out <= shreg[15];
            shreg    <= {shreg[14:0], 1'b0};
            slot_idx <= slot_idx + 1'b1;
        end
    end

    // ---------------- assertions ----------------
    // R1
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start) |=> $stable(line_out));

    // R7
    group_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && state != ST_ARM) |=> (line_out != $past(line_out)));

    // R3
    sub_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sf_cnt <= LAST_SUB);

    // R9
    ready_to_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_ready |=> (state == ST_SYNC && !sf_cnt[0]));

    // R11
    start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (line_out == 1'b0 && state == ST_ARM));

endmodule

// File: tb/sim_bmc_line_tx.sv
module sim_bmc_line_tx;

    localparam int DIV = 2;
    localparam int WD  = 150000;

    logic        clk = 1'b0;
    logic        rst_n, start, swap, pcm_valid;
    logic [15:0] pcm_left, pcm_right;
    logic        pcm_ready, line_out;

    always #4 clk = ~clk;

    bmc_line_tx #(.SLOT_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .swap(swap),
        .pcm_valid(pcm_valid), .pcm_left(pcm_left), .pcm_right(pcm_right),
        .pcm_ready(pcm_ready), .line_out(line_out)
    );

    // ---------------- behavioural model ----------------
    int    dc;
    bit    q[$];
    string tq[$];
    bit    exp_line;
    string exp_tag;
    bit    last_lvl;
    int    sfc;
    int    frames_made, ready_seen;
    bit    prev_tk, prev_start;
    int    n_cmp, n_bad;
    bit    done;
    bit    line_prev;

    task automatic chk(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic gen_sub(bit present, logic [15:0] s, string dtag);
        bit [31:0]   w;
        logic [15:0] pre;
        int          ones;
        bit          fl, lvl;
        w = '0;
        if (present) begin
            for (int k = 0; k < 16; k++) w[11+k] = s[k];
            w[27] = s[15];
            ones = 0;
            for (int k = 4; k < 31; k++) ones += w[k];
            w[31] = ones[0];
        end
        pre = (sfc == 0) ? 16'hE8CC : ((sfc % 2) == 1) ? 16'hE4CC : 16'hE2CC;
        fl = last_lvl;
        for (int k = 15; k >= 0; k--) begin
            q.push_back(pre[k] ^ fl);
            tq.push_back(fl ? "R7" : "R3");
        end
        lvl = pre[0] ^ fl;
        for (int b = 8; b < 32; b++) begin
            string t;
            if (b <= 10 || (b >= 27 && b <= 30)) t = "R4";
            else if (b == 31) t = "R5";
            else t = dtag;
            lvl = ~lvl;
            q.push_back(lvl); tq.push_back(t);
            lvl = lvl ^ w[b];
            q.push_back(lvl); tq.push_back(t);
        end
        last_lvl = lvl;
        sfc = (sfc + 1) % 384;
    endtask

    task automatic gen_frame(bit v, bit sw, logic [15:0] l, logic [15:0] r);
        logic [15:0] sl, sr;
        string dt;
        sl = sw ? {l[7:0], l[15:8]} : l;
        sr = sw ? {r[7:0], r[15:8]} : r;
        dt = !v ? "R10" : (sw ? "R8" : "R6");
        gen_sub(v, sl, dt);
        gen_sub(v, sr, dt);
        frames_made++;
    endtask

    always @(posedge clk) begin
        bit tk;
        if (!rst_n) begin
            dc = 0; q.delete(); tq.delete(); exp_line = 0; exp_tag = "R11";
            last_lvl = 0; sfc = 0; prev_tk = 0; prev_start = 0;
        end else begin
            tk = (dc == DIV - 1);
            dc = tk ? 0 : dc + 1;
            prev_tk = tk;
            prev_start = start;
            if (start) begin
                q.delete(); tq.delete(); exp_line = 0; exp_tag = "R11";
                last_lvl = 0; sfc = 0;
            end else if (tk) begin
                if (q.size() == 0) gen_frame(pcm_valid, swap, pcm_left, pcm_right);
                exp_line = q.pop_front();
                exp_tag  = tq.pop_front();
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                // R11 reset state
                chk(line_out == 1'b0 && pcm_ready == 1'b0, "R11", line_out, 0);
            end else begin
                bit exp_rdy;
                chk(line_out === exp_line, exp_tag, line_out, exp_line);
                // R1: no change away from a tick
                if (!prev_tk && !prev_start)
                    chk(line_out === line_prev, "R1", line_out, line_prev);
                // R9
                exp_rdy = (dc == DIV - 1) && (q.size() == 0) && !start;
                chk(pcm_ready === exp_rdy, "R9", pcm_ready, exp_rdy);
                if (pcm_ready) ready_seen++;
            end
            line_prev = line_out;
        end
    end

    // ---------------- stimulus ----------------
    int unsigned seed = 32'h1234_5678;
    logic [15:0] corner [6] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h0001, 16'h5A3C};

    task automatic run(int ncyc, int mode);
        for (int i = 0; i < ncyc; i++) begin
            @(posedge clk); #1;
            if (mode == 0) begin
                pcm_left  = corner[(i / 256) % 6];
                pcm_right = corner[(i / 256 + 3) % 6];
            end else begin
                seed = seed * 32'd1103515245 + 32'd12345;
                pcm_left  = seed[31:16];
                pcm_right = seed[15:0];
            end
        end
    endtask

    task automatic pulse_start(bit on_tick);
        @(posedge clk); #1;
        while ((dc == DIV - 1) != on_tick) begin @(posedge clk); #1; end
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    initial begin
        rst_n = 0; start = 0; swap = 0; pcm_valid = 0; pcm_left = 0; pcm_right = 0;
        n_cmp = 0; n_bad = 0; done = 0; frames_made = 0; ready_seen = 0; line_prev = 0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1;
        // R4 R5 R6: corner samples, little-endian
        pcm_valid = 1;
        run(20 * 256, 0);
        // R8: big-endian words
        swap = 1;
        run(10 * 256, 1);
        // R10: silence
        swap = 0; pcm_valid = 0;
        run(6 * 256, 1);
        // R11: start off a tick, then exactly on a tick
        pcm_valid = 1;
        run(1000, 1);
        pulse_start(1'b0);
        run(3 * 256 + 77, 1);
        pulse_start(1'b1);
        for (int p = 0; p < 8; p++) begin
            pcm_valid = p[0];
            run(700, 1);
        end
        // R3: cross the block wrap with data flowing
        pcm_valid = 1;
        run(200 * 256, 1);
        @(negedge clk);
        done = 1;
        // R2: one frame per handshake opportunity
        chk(ready_seen == frames_made, "R2", ready_seen, frames_made);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        done = 1;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", WD, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule